// File: doc/BRIEF.md
# Differential ADC Serial Read Controller

This block is the host-side sequencer for an external 12-bit differential sampling converter that is read over a three-wire synchronous link. The link has an active-low select, a serial clock driven by the host, and a single data line from the converter. A start request lowers the select line. The block then produces the serial clock from the system clock through a programmable divider and lets the converter sample for one and a half serial clock periods. After that it skips one null bit, shifts in twelve result bits most significant first, and raises the select line again.

The converter codes are signed two's complement: 800h is the most negative value and 7FFh the most positive. The block can run 2^k conversions back to back, with k from 0 to 4, and average them. It sign-extends and sums the codes, then shifts the sum right arithmetically by k. The final value is presented with a one-cycle done pulse. Averaging lowers the random noise in the reported code. The host sets the serial clock half period so that the low phase is longer than the converter's output delay, which is up to 150 ns.

Top module: `adc_read_ctrl`

## Requirements
- R1: After reset, cs_no is 1, sclk_o is 0, busy_o is 0 and done_o is 0.
- R2: A conversion frame holds cs_no low and produces exactly 15 rising edges of sclk_o. sclk_o is low whenever cs_no is high, and cs_no is low at least one system clock before any rising edge.
- R3: sdata_i is sampled at each rising edge of sclk_o. The values at rising edges 1 to 3 (the sampling window and the null bit) are discarded. Rising edges 4 to 15 deliver result bits 11 down to 0, most significant first.
- R4: Each serial clock half period is half_div_i+1 system clocks, using the value captured at start. The first rising edge comes half_div_i+1 clocks after cs_no falls.
- R5: result_o is the 12-bit two's-complement code, with 800h the most negative and 7FFh the most positive value.
- R6: No bit is captured while cs_no is high. cs_no rises and sclk_o falls in the same cycle, one half period after the last rising edge.
- R7: avg_log2_i = k, captured at start, runs 2^k conversions. Values above 4 are treated as 4. result_o is the sum of the sign-extended codes shifted right arithmetically by k; for example, FFFh and FFEh with k=1 give FFEh.
- R8: done_o is a single-cycle pulse in the first idle cycle, when result_o is valid. busy_o is high from the cycle after start until then. start_i is ignored while busy_o is high.
- R9: Back-to-back conversions in one averaging run are separated by exactly one half period with cs_no high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, taken when idle |
| half_div_i | input | 8 | Serial clock half period minus one, in system clocks |
| avg_log2_i | input | 3 | log2 of the number of averaged conversions (0..4, larger clamps to 4) |
| sdata_i | input | 1 | Serial data from the converter |
| cs_no | output | 1 | Active-low converter select |
| sclk_o | output | 1 | Serial clock to the converter |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle result valid pulse |
| result_o | output | 12 | Signed (averaged) result |

## Verification
The assertions check the link discipline on every cycle. They check that the serial clock stays low while the select line is high, that the select line is low before each rising edge, and that no capture happens while the select line is high. They also check that done is a single-cycle pulse arriving in idle, and that a start taken in idle makes the block busy. Only the bench scenarios can show that the right data bits are kept and the null bit is discarded, and that the half period and inter-frame gap have the programmed lengths. The bench scenarios also cover the frame length of 15 rising edges, the clamping of k, and arithmetic rounding toward minus infinity in the averaged result.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FRAME = 2'd1,
    ST_GAP   = 2'd2
  } rd_state_e;
endpackage

// File: rtl/adc_rd_sclk_div.sv
module adc_rd_sclk_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/adc_rd_shift.sv
module adc_rd_shift #(
  parameter int DATA_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              bit_i,
  output logic [DATA_W-1:0] code_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   code_o <= '0;
    else if (en_i) code_o <= {code_o[DATA_W-2:0], bit_i};
  end
endmodule

// File: rtl/adc_rd_accum.sv
module adc_rd_accum #(
  parameter int DATA_W = 12,
  parameter int ACC_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              add_i,
  input  logic [DATA_W-1:0] code_i,
  output logic [ACC_W-1:0]  sum_o
);
  localparam int EXT_W = ACC_W - DATA_W;
  logic [ACC_W-1:0] acc_q;

  // running sum including the code being added this cycle
  assign sum_o = acc_q + {{EXT_W{code_i[DATA_W-1]}}, code_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    acc_q <= '0;
    else if (clr_i) acc_q <= '0;
    else if (add_i) acc_q <= sum_o;
  end
endmodule

// File: rtl/adc_read_ctrl.sv
module adc_read_ctrl #(
  parameter int DATA_W       = 12,
  parameter int DIV_W        = 8,
  parameter int SAMPLE_RISES = 2,
  parameter int MAX_LOG2     = 4,
  parameter int LOG2_W       = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DIV_W-1:0]  half_div_i,
  input  logic [LOG2_W-1:0] avg_log2_i,
  input  logic              sdata_i,
  output logic              cs_no,
  output logic              sclk_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] result_o
);
  import adc_rd_pkg::*;

  localparam int ACC_W   = DATA_W + MAX_LOG2;
  localparam int CNT_W   = MAX_LOG2 + 1;
  localparam int H_FIRST = 2 * (SAMPLE_RISES + 1);          // low phase before first data rise
  localparam int H_LAST  = 2 * (SAMPLE_RISES + 1 + DATA_W) - 1;
  localparam int H_W     = $clog2(H_LAST + 1);

  rd_state_e         state_q;
  logic [H_W-1:0]    h_q;
  logic [DIV_W-1:0]  div_q;
  logic [LOG2_W-1:0] k_q;
  logic [MAX_LOG2-1:0] left_q;
  logic              done_q;
  logic [DATA_W-1:0] result_q;

  logic              tick, run, cap_en, conv_end, clr;
  logic [LOG2_W-1:0] k_eff;
  logic [CNT_W-1:0]  n_conv;
  logic [DATA_W-1:0] code;
  logic [ACC_W-1:0]  sum;
  logic signed [ACC_W-1:0] avg;

  assign k_eff  = (avg_log2_i > LOG2_W'(MAX_LOG2)) ? LOG2_W'(MAX_LOG2) : avg_log2_i;
  assign n_conv = CNT_W'(1) << k_eff;

  assign run      = (state_q != ST_IDLE);
  assign cap_en   = (state_q == ST_FRAME) && tick && !h_q[0] && (h_q >= H_W'(H_FIRST));
  assign conv_end = (state_q == ST_FRAME) && tick && (h_q == H_W'(H_LAST));
  assign clr      = (state_q == ST_IDLE) && start_i;
  assign avg      = $signed(sum) >>> k_q;

  adc_rd_sclk_div #(.DIV_W(DIV_W)) u_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (run),
    .div_i (div_q),
    .tick_o(tick)
  );

  adc_rd_shift #(.DATA_W(DATA_W)) u_shift (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (cap_en),
    .bit_i (sdata_i),
    .code_o(code)
  );

  adc_rd_accum #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_acc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr),
    .add_i (conv_end),
    .code_i(code),
    .sum_o (sum)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      h_q      <= '0;
      div_q    <= '0;
      k_q      <= '0;
      left_q   <= '0;
      done_q   <= 1'b0;
      result_q <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          div_q   <= half_div_i;
          k_q     <= k_eff;
          left_q  <= MAX_LOG2'(n_conv - 1'b1);
          h_q     <= '0;
          state_q <= ST_FRAME;
        end
        ST_FRAME: if (tick) begin
          if (h_q == H_W'(H_LAST)) begin
            h_q <= '0;
            if (left_q == '0) begin
              state_q  <= ST_IDLE;
              done_q   <= 1'b1;
              result_q <= avg[DATA_W-1:0];
            end else begin
              left_q  <= left_q - 1'b1;
              state_q <= ST_GAP;
            end
          end else begin
            h_q <= h_q + 1'b1;
          end
        end
        ST_GAP: if (tick) state_q <= ST_FRAME;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cs_no    = (state_q != ST_FRAME);
  assign sclk_o   = (state_q == ST_FRAME) && h_q[0];
  assign busy_o   = run;
  assign done_o   = done_q;
  assign result_o = result_q;
endmodule

// File: rtl/adc_rd_chk.sv
module adc_rd_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic cs_no,
  input logic sclk_o,
  input logic busy_o,
  input logic done_o,
  input logic cap_en
);
  a_r2_sclk_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sclk_o);

  a_r2_cs_before_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sclk_o) |-> $past(!cs_no));

  a_r6_no_capture_cs_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_en |-> (!cs_no && !sclk_o));

  a_r8_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r8_done_in_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && cs_no));

  a_r8_start_takes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);
endmodule

bind adc_read_ctrl adc_rd_chk u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .start_i(start_i),
  .cs_no  (cs_no),
  .sclk_o (sclk_o),
  .busy_o (busy_o),
  .done_o (done_o),
  .cap_en (cap_en)
);

// File: tb/tb_adc_read_ctrl.sv
`timescale 1ns/1ps
module tb_adc_read_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  div = 8'd0;
  logic [2:0]  k = 3'd0;
  logic        sdata = 1'b1;
  logic        cs_n, sclk, busy, done;
  logic [11:0] result;

  int n_tests = 0, n_fail = 0;

  adc_read_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .half_div_i(div),
    .avg_log2_i(k), .sdata_i(sdata), .cs_no(cs_n), .sclk_o(sclk),
    .busy_o(busy), .done_o(done), .result_o(result)
  );

  always #4 clk = ~clk;

  // converter model: null bit driven as 1 so a kept null bit shows up
  logic [11:0] codes [16];
  int conv_idx = 0, fall_cnt = 0;
  int rise_cnt = 0, last_rises = 0, frames = 0;
  int meas_low = 0, meas_gap = 0;
  bit seen_first = 1'b0;
  realtime cs_fall_t = 0, cs_rise_t = 0;

  always @(negedge cs_n) begin
    fall_cnt   = 0;
    sdata      = 1'b1;
    cs_fall_t  = $realtime;
    seen_first = 1'b0;
    if (frames > 0) meas_gap = $rtoi(($realtime - cs_rise_t) / 8.0 + 0.5);
  end

  always @(negedge sclk) if (!cs_n) begin
    fall_cnt++;
    if (fall_cnt >= 3 && fall_cnt <= 14) sdata = codes[conv_idx % 16][14 - fall_cnt];
    else sdata = 1'b1;
  end

  always @(posedge sclk) if (!cs_n) begin
    if (!seen_first) begin
      meas_low   = $rtoi(($realtime - cs_fall_t) / 8.0 + 0.5);
      seen_first = 1'b1;
    end
    rise_cnt++;
  end

  always @(posedge cs_n) begin
    last_rises = rise_cnt;
    rise_cnt   = 0;
    frames++;
    conv_idx++;
    cs_rise_t  = $realtime;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run(input int kk, input int dv);
    bit got = 1'b0;
    @(negedge clk);
    k = 3'(kk); div = 8'(dv);
    frames = 0; conv_idx = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 40000; i++) begin
      if (done) begin got = 1'b1; break; end
      @(negedge clk);
    end
    chk(got, "R8", "done seen", int'(got), 1);
  endtask

  function automatic int exp_avg(input int kk);
    int ke = (kk > 4) ? 4 : kk;
    int sum = 0;
    for (int i = 0; i < (1 << ke); i++) sum += int'($signed(codes[i]));
    return (sum >>> ke) & 12'hFFF;
  endfunction

  task automatic t_reset();
    chk(cs_n == 1'b1, "R1", "cs_no", int'(cs_n), 1);
    chk(sclk == 1'b0, "R1", "sclk_o", int'(sclk), 0);
    chk(busy == 1'b0, "R1", "busy_o", int'(busy), 0);
    chk(done == 1'b0, "R1", "done_o", int'(done), 0);
  endtask

  task automatic t_single(input logic [11:0] code, input int dv);
    codes[0] = code;
    run(0, dv);
    chk(result == code, "R3", "single result", int'(result), int'(code));
    chk(last_rises == 15, "R2", "rising edges", last_rises, 15);
    chk(meas_low == dv + 1, "R4", "first low phase", meas_low, dv + 1);
    chk(frames == 1, "R7", "frames k=0", frames, 1);
    chk(!busy, "R8", "busy after done", int'(busy), 0);
    @(negedge clk);
    chk(!done, "R8", "done pulse width", int'(done), 0);
    chk(cs_n && !sclk, "R6", "link idle after frame", int'({cs_n, sclk}), 2);
  endtask

  task automatic t_avg(input int kk, input int dv, input string req);
    int ke = (kk > 4) ? 4 : kk;
    int e;
    e = exp_avg(kk);
    run(kk, dv);
    chk(result == 12'(e), req, "average", int'(result), e);
    chk(frames == (1 << ke), "R7", "conversion count", frames, 1 << ke);
    if (ke > 0) chk(meas_gap == dv + 1, "R9", "inter-frame gap", meas_gap, dv + 1);
  endtask

  task automatic t_busy_start();
    codes[0] = 12'h123; codes[1] = 12'h123; codes[2] = 12'h123; codes[3] = 12'h123;
    @(negedge clk);
    k = 3'd2; div = 8'd1; frames = 0; conv_idx = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (70) @(negedge clk);
    start = 1'b1; k = 3'd0; div = 8'd5;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 20000; i++) begin
      if (done) break;
      @(negedge clk);
    end
    chk(frames == 4, "R8", "start ignored while busy", frames, 4);
    chk(result == 12'h123, "R8", "result unaffected", int'(result), 'h123);
    repeat (200) @(negedge clk);
    chk(!busy && cs_n, "R8", "no extra run", int'(busy), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    // R5 extremes, R3 MSB-first with null and window bits discarded
    t_single(12'h7FF, 0);
    t_single(12'h800, 2);
    t_single(12'hA5C, 5);
    t_single(12'h001, 1);
    codes[0] = 12'h7FF; codes[1] = 12'h001;
    t_avg(1, 1, "R7");                     // 2048>>>1 = 400h
    codes[0] = 12'hFFF; codes[1] = 12'hFFE;
    t_avg(1, 0, "R7");                     // -3>>>1 = FFEh
    for (int i = 0; i < 4; i++) codes[i] = 12'h800;
    t_avg(2, 3, "R5");                     // stays at negative full scale
    for (int i = 0; i < 16; i++) codes[i] = 12'(i * 300 - 2000);
    t_avg(7, 2, "R7");                     // k clamps to 4
    t_busy_start();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule